// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit unsigned operands and a carry input. Its result is a 16-bit sum and a carry output. It is purely combinational. The operands are cut into four slices of four bits each. Every slice forms its per-bit generate and propagate terms. From those terms and its own incoming carry, each slice writes its internal carries as flat sum-of-products expressions.

Every slice also reports a slice-level generate and propagate. A second lookahead stage takes these four pairs and the carry input. From them it forms the carries into slices 1, 2 and 3 and the final carry output, all in parallel. No carry ever ripples from one slice to the next.

The same four-term equations are used at both levels. This keeps the fan-in of each term at five inputs or fewer, while the carry path stays at two lookahead levels deep. A system places the block wherever a wide add must settle within a single cycle's logic budget.

Top module: `cla_adder16`

## Requirements
- R1: `sum_out` equals (`a_in` + `b_in` + `carry_in`) modulo 65536, with all operands taken as unsigned.
- R2: `carry_out` equals bit 16 of the 17-bit unsigned total `a_in` + `b_in` + `carry_in`.
- R3: When every bit pair differs (`a_in` ^ `b_in` = 16'hFFFF), the outputs follow `carry_in` alone: a carry input of 1 gives sum 0 and carry_out 1, and a carry input of 0 gives sum 16'hFFFF and carry_out 0.
- R4: A carry produced in any slice reaches the slice above it. For slice k (bits 4k+3 to 4k), a nibble of 4'hF plus 4'h1 in that slice with zeros elsewhere sets bit 4k+4 of the total.
- R5: Within each slice, the slice generate and the slice propagate are never both 1.
- R6: The carries produced by the second lookahead stage equal the ripple recurrence c[k+1] = G[k] | (P[k] & c[k]) applied to the slice signals.
- R7: The block holds no state. The outputs reflect the present inputs with no clock edge needed, and all-zero inputs give sum 0 and carry_out 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First addend |
| b_in | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Low 16 bits of the total |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
Each slice is swept exhaustively in turn. All 512 combinations of its two nibbles and the carry input are applied while the other slices hold fixed backgrounds of all-zeros or all-propagate. This separates a wrong in-slice carry term from a wrong second-level term that feeds the slices above.

Directed patterns cover the full 16-bit propagate chain, a carry generated at each slice boundary, and the maximum operands. These isolate the long group-propagate products of the second lookahead stage. A few thousand random operand pairs then exercise mixed generate, propagate and kill slices across the full width.

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int unsigned LA_MAX = 32;

  // Carry into position k of a lookahead block, written as the flat OR of
  // product terms: each generate j<k ANDed with all propagates above it,
  // plus the full propagate product ANDed with the incoming carry.
  function automatic logic la_carry(input logic [LA_MAX-1:0] g,
                                    input logic [LA_MAX-1:0] p,
                                    input logic c0,
                                    input int unsigned k);
    logic acc;
    logic term;
    term = c0;
    for (int unsigned j = 0; j < LA_MAX; j++)
      if (j < k) term = term & p[j];
    acc = term;
    for (int unsigned j = 0; j < LA_MAX; j++) begin
      if (j < k) begin
        term = g[j];
        for (int unsigned m = 0; m < LA_MAX; m++)
          if (m > j && m < k) term = term & p[m];
        acc = acc | term;
      end
    end
    return acc;
  endfunction

  // Block generate over the low n positions (carry-in taken as zero).
  function automatic logic la_block_gen(input logic [LA_MAX-1:0] g,
                                        input logic [LA_MAX-1:0] p,
                                        input int unsigned n);
    return la_carry(g, p, 1'b0, n);
  endfunction

  // Block propagate over the low n positions.
  function automatic logic la_block_prop(input logic [LA_MAX-1:0] p,
                                         input int unsigned n);
    logic acc;
    acc = 1'b1;
    for (int unsigned j = 0; j < LA_MAX; j++)
      if (j < n) acc = acc & p[j];
    return acc;
  endfunction

endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] gen,
  output logic [W-1:0] prop
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen[i]  = a[i] & b[i];
    assign prop[i] = a[i] ^ b[i];
  end

  always_comb begin
    if (!$isunknown({a, b})) begin
      // R5 support: a position cannot both generate and propagate
      p_bit_exclusive_r5: assert ((gen & prop) == '0)
        else $error("bit generate and propagate overlap");
    end
  end
endmodule

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         cin,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         group_g,
  output logic         group_p
);
  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W:0]   carry;
  logic [LA_MAX-1:0] gen_x;
  logic [LA_MAX-1:0] prop_x;

  cla_bit_pg #(.W(W)) u_pg (
    .a    (a),
    .b    (b),
    .gen  (gen),
    .prop (prop)
  );

  assign gen_x  = LA_MAX'(gen);
  assign prop_x = LA_MAX'(prop);

  for (genvar k = 0; k <= W; k++) begin : g_carry
    assign carry[k] = la_carry(gen_x, prop_x, cin, k);
  end

  assign sum     = prop ^ carry[W-1:0];
  assign group_g = la_block_gen(gen_x, prop_x, W);
  assign group_p = la_block_prop(prop_x, W);

  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      p_group_excl_r5: assert (!(group_g && group_p))
        else $error("group generate and propagate both set");
      p_group_sum_r1: assert ({carry[W], sum} == ({1'b0, a} + {1'b0, b} + (W+1)'(cin)))
        else $error("group lookahead disagrees with arithmetic");
      p_group_cout_r6: assert (carry[W] == (group_g | (group_p & cin)))
        else $error("group carry-out disagrees with group signals");
    end
  end
endmodule

// File: rtl/cla_second_level.sv
module cla_second_level
  import cla_pkg::*;
#(
  parameter int unsigned NG = 4
) (
  input  logic          cin,
  input  logic [NG-1:0] grp_g,
  input  logic [NG-1:0] grp_p,
  output logic [NG:0]   grp_c
);
  logic [LA_MAX-1:0] g_x;
  logic [LA_MAX-1:0] p_x;
  logic [NG:0]       ripple_ref;

  assign g_x = LA_MAX'(grp_g);
  assign p_x = LA_MAX'(grp_p);

  for (genvar k = 0; k <= NG; k++) begin : g_gc
    assign grp_c[k] = la_carry(g_x, p_x, cin, k);
  end

  // Ripple reference used only by the assertion below.
  always_comb begin
    ripple_ref[0] = cin;
    for (int k = 0; k < NG; k++)
      ripple_ref[k+1] = grp_g[k] | (grp_p[k] & ripple_ref[k]);
  end

  always_comb begin
    if (!$isunknown({grp_g, grp_p, cin})) begin
      p_lookahead_ripple_r6: assert (grp_c == ripple_ref)
        else $error("second-level carries differ from ripple recurrence");
      p_first_carry_r7: assert (grp_c[0] == cin)
        else $error("carry into group 0 is not the input carry");
    end
  end
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
  import cla_pkg::*;
#(
  parameter int unsigned GROUP_W = 4,
  parameter int unsigned GROUPS  = 4,
  localparam int unsigned WIDTH  = GROUP_W * GROUPS
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);
  logic [GROUPS-1:0] grp_g;
  logic [GROUPS-1:0] grp_p;
  logic [GROUPS:0]   grp_c;

  for (genvar k = 0; k < GROUPS; k++) begin : g_grp
    cla_group #(.W(GROUP_W)) u_group (
      .cin     (grp_c[k]),
      .a       (a_in[k*GROUP_W +: GROUP_W]),
      .b       (b_in[k*GROUP_W +: GROUP_W]),
      .sum     (sum_out[k*GROUP_W +: GROUP_W]),
      .group_g (grp_g[k]),
      .group_p (grp_p[k])
    );
  end

  cla_second_level #(.NG(GROUPS)) u_lvl2 (
    .cin   (carry_in),
    .grp_g (grp_g),
    .grp_p (grp_p),
    .grp_c (grp_c)
  );

  assign carry_out = grp_c[GROUPS];

  always_comb begin
    if (!$isunknown({a_in, b_in, carry_in})) begin
      p_total_r1_r2: assert ({carry_out, sum_out} ==
                              ({1'b0, a_in} + {1'b0, b_in} + (WIDTH+1)'(carry_in)))
        else $error("adder total wrong");
      p_full_prop_r3: assert (!((a_in ^ b_in) == '1) || (carry_out == carry_in))
        else $error("full propagate chain broken");
    end
  end
endmodule

// File: tb/tb_cla_adder16.sv
module tb_cla_adder16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [15:0] a_in, b_in, sum_out;
  logic        carry_in, carry_out;
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  cla_adder16 dut (
    .a_in      (a_in),
    .b_in      (b_in),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out)
  );

  task automatic check(input string req, input logic [16:0] got, input logic [16:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h ci=%0b actual=%h expected=%h", req, a_in, b_in, carry_in, got, exp);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c);
    a_in = a; b_in = b; carry_in = c;
    #1;
  endtask

  task automatic check_total(input string req);
    logic [16:0] exp;
    exp = 17'(a_in) + 17'(b_in) + 17'(carry_in);
    check(req, {carry_out, sum_out}, exp);
  endtask

  initial begin
    a_in = '0; b_in = '0; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7: all-zero inputs, no clock edge required
    apply(16'h0, 16'h0, 1'b0);
    check("R7", {carry_out, sum_out}, 17'h0);

    // R1/R2/R5: exhaustive per slice on zero and all-propagate backgrounds
    for (int s = 0; s < 4; s++)
      for (int bg = 0; bg < 2; bg++)
        for (int v = 0; v < 512; v++) begin
          logic [15:0] a, b, mask;
          mask = 16'hF << (4*s);
          a = bg ? (16'hAAAA & ~mask) : 16'h0;
          b = bg ? (16'h5555 & ~mask) : 16'h0;
          a = a | (16'(v[3:0]) << (4*s));
          b = b | (16'(v[7:4]) << (4*s));
          apply(a, b, v[8]);
          check_total("R1_R2_R5");
        end

    // R3: full propagate chain
    apply(16'hFFFF, 16'h0000, 1'b1); check("R3", {carry_out, sum_out}, 17'h10000);
    apply(16'hA5C3, 16'h5A3C, 1'b1); check("R3", {carry_out, sum_out}, 17'h10000);
    apply(16'hA5C3, 16'h5A3C, 1'b0); check("R3", {carry_out, sum_out}, 17'h0FFFF);

    // R4: carry generated in slice k reaches bit 4k+4
    for (int k = 0; k < 4; k++) begin
      logic [16:0] exp;
      exp = 17'h1 << (4*k + 4);
      apply(16'hF << (4*k), 16'h1 << (4*k), 1'b0);
      check("R4", {carry_out, sum_out}, exp);
    end

    // R6: generate in slice 0 propagating through slices above
    apply(16'h000F, 16'hFFF1, 1'b0); check("R6", {carry_out, sum_out}, 17'h10000);
    apply(16'h00F8, 16'hFF08, 1'b0); check("R6", {carry_out, sum_out}, 17'h10000);
    apply(16'hFFFF, 16'hFFFF, 1'b1); check("R2", {carry_out, sum_out}, 17'h1FFFF);
    apply(16'h8000, 16'h8000, 1'b0); check("R2", {carry_out, sum_out}, 17'h10000);

    // R1/R2: random full-width operands
    for (int i = 0; i < 4000; i++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom));
      check_total("R1_R2");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule